// File: doc/BRIEF.md
# Single-Bus Processor Control Sequencer

This block is the control unit of a small accumulator processor built around one shared internal bus. The processor has a 16-bit datapath and a 12-bit address space. Each instruction word carries a 4-bit opcode in its top bits and a 12-bit address operand in its low bits. The sequencer reads the opcode from the instruction register and drives four things: a one-hot select that picks which unit drives the bus, the register load and increment strobes, and the active-low external memory controls.

The state machine has eight states. Every instruction starts with a three-state fetch: address setup, address hold, then a data read. After the fetch, the opcode in the instruction register sorts the instruction into one of three classes: store, jump or other. The state register and the instruction register together set the outputs.

- A jump loads the PC from the operand in one cycle and does no memory cycle.
- A store places the accumulator on the bus around a single write state, so the data is stable before and after the write.
- Any other opcode reads memory at the operand address and then loads the accumulator.

Control pins are plain levels. There is no streaming interface.

Top module: `cpu_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the fetch address-setup state. The outputs are then: bus_sel=4'b0001, mem_en_n=0, mem_oe_n=1, mem_rnw=1, adr_stb_n=1, and all load and increment strobes low.
- R2: Exactly one bit of bus_sel is high in every cycle. The bits select, from bit 0 up: the PC, the instruction-register operand, the accumulator and the memory data.
- R3: The PC select (bus_sel bit 0) is high only in the two fetch address states and low in every other state.
- R4: A fetch takes three cycles, in this order:
  - PC on the bus with mem_en_n=0;
  - the same plus adr_stb_n=0;
  - memory data on the bus with mem_en_n=0, mem_oe_n=0, ld_ir=1 and inc_pc=1.
- R5: An opcode equal to parameter ST_OP is a store, and one equal to JMP_OP is a jump. Every other value is an "other" opcode. The class comes from the opcode present in the cycle after the fetch data read.
- R6: A jump takes one cycle after the fetch. In that cycle the operand is on the bus, ld_pc=1 and mem_en_n=1. The next cycle is a fetch address setup.
- R7: A store takes five cycles after the fetch, in this order:
  - operand on the bus, mem_en_n=0;
  - operand on the bus, adr_stb_n=0;
  - accumulator on the bus, mem_rnw=1;
  - accumulator on the bus, mem_rnw=0;
  - accumulator on the bus, mem_rnw=1.
  mem_en_n is low throughout. Then the sequencer fetches again.
- R8: An "other" opcode takes four cycles after the fetch, in this order:
  - operand on the bus, mem_en_n=0;
  - operand on the bus, adr_stb_n=0;
  - memory data on the bus with mem_oe_n=0;
  - memory data on the bus with mem_oe_n=0 and ld_acc=1.
  Then the sequencer fetches again.
- R9: mem_oe_n and mem_rnw are never low in the same cycle. mem_rnw is never low for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_opcode | input | OPC_W | Opcode field of the instruction register |
| bus_sel | output | 4 | One-hot bus source select: PC, operand, accumulator, memory |
| ld_ir | output | 1 | Load instruction register from bus |
| inc_pc | output | 1 | Increment program counter |
| ld_pc | output | 1 | Load program counter from bus |
| ld_acc | output | 1 | Load accumulator through the ALU from bus |
| mem_en_n | output | 1 | Memory enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_rnw | output | 1 | Read (1) / write (0) |
| adr_stb_n | output | 1 | Address hold strobe, active low |

## Verification
The bench builds the sequencer with ST_OP=4'hA and JMP_OP=4'h3 instead of the defaults 4'h2 and 4'h7. This shows that the class decode follows the parameters. It also means the default store code 4'h2 must now run as an "other" instruction. Opcodes at both ends of the code space (4'h0, 4'hF) are exercised. So is a reset issued in the middle of a store's write state.

// File: rtl/cpu_seq_pkg.sv
package cpu_seq_pkg;
  localparam int NUM_STATES = 8;
  localparam int ST_W = $clog2(NUM_STATES);
  localparam int SEL_W = 4;

  // bus source positions inside the select vector
  localparam int SRC_PC  = 0;
  localparam int SRC_OPR = 1;
  localparam int SRC_ACC = 2;
  localparam int SRC_MEM = 3;

  typedef enum logic [ST_W-1:0] {
    ST_FA, ST_FH, ST_FD,          // fetch: addr setup, addr hold, data read
    ST_XA, ST_XH, ST_XD, ST_XE, ST_XF
  } st_t;

  typedef enum logic [1:0] {
    CL_OTHER = 2'd0,
    CL_STORE = 2'd1,
    CL_JUMP  = 2'd2
  } cls_t;

  // active-high control intents
  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic ld_ir;
    logic inc_pc;
    logic ld_pc;
    logic ld_acc;
    logic me;
    logic oe;
    logic wr;
    logic stb;
  } ctl_t;
endpackage

// File: rtl/cpu_seq_classify.sv
module cpu_seq_classify
  import cpu_seq_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter logic [OPC_W-1:0] ST_OP = 4'h2,
  parameter logic [OPC_W-1:0] JMP_OP = 4'h7
) (
  input  logic [OPC_W-1:0] opcode,
  output cls_t             cls
);
  always_comb begin
    if (opcode == ST_OP)       cls = CL_STORE;
    else if (opcode == JMP_OP) cls = CL_JUMP;
    else                       cls = CL_OTHER;
  end
endmodule

// File: rtl/cpu_seq_fsm.sv
module cpu_seq_fsm
  import cpu_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cls_t cls,
  output st_t  state
);
  st_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FA: nxt = ST_FH;
      ST_FH: nxt = ST_FD;
      ST_FD: nxt = ST_XA;
      ST_XA: nxt = (cls == CL_JUMP) ? ST_FA : ST_XH;
      ST_XH: nxt = ST_XD;
      ST_XD: nxt = ST_XE;
      ST_XE: nxt = (cls == CL_STORE) ? ST_XF : ST_FA;
      ST_XF: nxt = ST_FA;
      default: nxt = ST_FA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FA;
    else     state <= nxt;
  end
endmodule

// File: rtl/cpu_seq_outdec.sv
module cpu_seq_outdec
  import cpu_seq_pkg::*;
(
  input  st_t  state,
  input  cls_t cls,
  output ctl_t ctl
);
  always_comb begin
    ctl = '0;
    unique case (state)
      ST_FA: begin ctl.sel[SRC_PC] = 1'b1; ctl.me = 1'b1; end
      ST_FH: begin ctl.sel[SRC_PC] = 1'b1; ctl.me = 1'b1; ctl.stb = 1'b1; end
      ST_FD: begin
        ctl.sel[SRC_MEM] = 1'b1; ctl.me = 1'b1; ctl.oe = 1'b1;
        ctl.ld_ir = 1'b1; ctl.inc_pc = 1'b1;
      end
      ST_XA: begin
        ctl.sel[SRC_OPR] = 1'b1;
        if (cls == CL_JUMP) ctl.ld_pc = 1'b1;
        else                ctl.me = 1'b1;
      end
      ST_XH: begin ctl.sel[SRC_OPR] = 1'b1; ctl.me = 1'b1; ctl.stb = 1'b1; end
      ST_XD: begin
        ctl.me = 1'b1;
        if (cls == CL_STORE) ctl.sel[SRC_ACC] = 1'b1;
        else begin ctl.sel[SRC_MEM] = 1'b1; ctl.oe = 1'b1; end
      end
      ST_XE: begin
        ctl.me = 1'b1;
        if (cls == CL_STORE) begin ctl.sel[SRC_ACC] = 1'b1; ctl.wr = 1'b1; end
        else begin ctl.sel[SRC_MEM] = 1'b1; ctl.oe = 1'b1; ctl.ld_acc = 1'b1; end
      end
      ST_XF: begin ctl.sel[SRC_ACC] = 1'b1; ctl.me = 1'b1; end
      default: ctl.sel[SRC_PC] = 1'b1;
    endcase
  end
endmodule

// File: rtl/cpu_seq.sv
module cpu_seq
  import cpu_seq_pkg::*;
#(
  parameter int OPC_W = 4,
  parameter logic [OPC_W-1:0] ST_OP = 4'h2,
  parameter logic [OPC_W-1:0] JMP_OP = 4'h7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] ir_opcode,
  output logic [3:0]       bus_sel,
  output logic             ld_ir,
  output logic             inc_pc,
  output logic             ld_pc,
  output logic             ld_acc,
  output logic             mem_en_n,
  output logic             mem_oe_n,
  output logic             mem_rnw,
  output logic             adr_stb_n
);
  cls_t cls;
  st_t  state_q;
  ctl_t ctl;

  cpu_seq_classify #(.OPC_W(OPC_W), .ST_OP(ST_OP), .JMP_OP(JMP_OP)) u_cls (
    .opcode(ir_opcode), .cls(cls)
  );

  cpu_seq_fsm u_fsm (.clk(clk), .rst(rst), .cls(cls), .state(state_q));

  cpu_seq_outdec u_dec (.state(state_q), .cls(cls), .ctl(ctl));

  // pad-side polarity: strobes leave the block inverted
  assign bus_sel   = ctl.sel;
  assign ld_ir     = ctl.ld_ir;
  assign inc_pc    = ctl.inc_pc;
  assign ld_pc     = ctl.ld_pc;
  assign ld_acc    = ctl.ld_acc;
  assign mem_en_n  = ~ctl.me;
  assign mem_oe_n  = ~ctl.oe;
  assign mem_rnw   = ~ctl.wr;
  assign adr_stb_n = ~ctl.stb;
endmodule

// File: rtl/cpu_seq_chk.sv
module cpu_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state,
  input logic [3:0] bus_sel,
  input logic       ld_pc,
  input logic       ld_ir,
  input logic       mem_en_n,
  input logic       mem_oe_n,
  input logic       mem_rnw
);
  a_r2_one_driver: assert property (@(posedge clk) disable iff (rst)
    $countones(bus_sel) == 1);

  a_r3_pc_fetch_only: assert property (@(posedge clk) disable iff (rst)
    bus_sel[0] |-> (state == 3'd0 || state == 3'd1));

  a_r4_setup_to_hold: assert property (@(posedge clk) disable iff (rst)
    state == 3'd0 |=> state == 3'd1);

  a_r4_hold_to_read: assert property (@(posedge clk) disable iff (rst)
    state == 3'd1 |=> state == 3'd2 && ld_ir);

  a_r6_jump_refetch: assert property (@(posedge clk) disable iff (rst)
    ld_pc |=> state == 3'd0);

  a_r6_jump_no_mem: assert property (@(posedge clk) disable iff (rst)
    ld_pc |-> mem_en_n);

  a_r7_write_from_acc: assert property (@(posedge clk) disable iff (rst)
    !mem_rnw |-> (bus_sel[2] && !mem_en_n));

  a_r9_write_single: assert property (@(posedge clk) disable iff (rst)
    !mem_rnw |=> mem_rnw);

  a_r9_no_oe_write: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_rnw));
endmodule

bind cpu_seq cpu_seq_chk u_chk (
  .clk(clk), .rst(rst), .state(state_q), .bus_sel(bus_sel), .ld_pc(ld_pc),
  .ld_ir(ld_ir), .mem_en_n(mem_en_n), .mem_oe_n(mem_oe_n), .mem_rnw(mem_rnw)
);

// File: tb/tb_cpu_seq.sv
`timescale 1ns/1ps
module tb_cpu_seq;
  localparam logic [3:0] TB_ST  = 4'hA;
  localparam logic [3:0] TB_JMP = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] ir_opcode = 4'h0;
  logic [3:0] bus_sel;
  logic ld_ir, inc_pc, ld_pc, ld_acc, mem_en_n, mem_oe_n, mem_rnw, adr_stb_n;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cpu_seq #(.OPC_W(4), .ST_OP(TB_ST), .JMP_OP(TB_JMP)) dut (
    .clk(clk), .rst(rst), .ir_opcode(ir_opcode), .bus_sel(bus_sel),
    .ld_ir(ld_ir), .inc_pc(inc_pc), .ld_pc(ld_pc), .ld_acc(ld_acc),
    .mem_en_n(mem_en_n), .mem_oe_n(mem_oe_n), .mem_rnw(mem_rnw),
    .adr_stb_n(adr_stb_n)
  );

  // {sel[3:0], ld_ir, inc_pc, ld_pc, ld_acc, me_n, oe_n, rnw, stb_n}
  function automatic logic [11:0] outs();
    return {bus_sel, ld_ir, inc_pc, ld_pc, ld_acc, mem_en_n, mem_oe_n, mem_rnw, adr_stb_n};
  endfunction

  // cls: 0 other, 1 store, 2 jump
  function automatic logic [11:0] expv(int cls, int i);
    case (i)
      0: return 12'b0001_0000_0111;
      1: return 12'b0001_0000_0110;
      2: return 12'b1000_1100_0011;
      3: return (cls == 2) ? 12'b0010_0010_1111 : 12'b0010_0000_0111;
      4: return 12'b0010_0000_0110;
      5: return (cls == 1) ? 12'b0100_0000_0111 : 12'b1000_0000_0011;
      6: return (cls == 1) ? 12'b0100_0000_0101 : 12'b1000_0001_0011;
      default: return 12'b0100_0000_0111;
    endcase
  endfunction

  function automatic int seqlen(int cls);
    return (cls == 2) ? 4 : (cls == 1) ? 8 : 7;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [11:0] act,
                     input logic [11:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle invariants R2, R3, R9
  task automatic chk_inv(input int i);
    chk($countones(bus_sel) == 1, "R2", {8'd0, bus_sel}, 12'd1);
    chk(bus_sel[0] == (i < 2), "R3", {11'd0, bus_sel[0]}, {11'd0, (i < 2)});
    chk(!(!mem_oe_n && !mem_rnw), "R9", {10'd0, mem_oe_n, mem_rnw}, 12'd1);
  endtask

  // runs one instruction from fetch setup; called at a negedge in cycle 0
  task automatic run_instr(input logic [3:0] op, input int cls, input string req,
                           input int stop_at);
    int n = seqlen(cls);
    for (int i = 0; i < n && i < stop_at; i++) begin
      chk(outs() == expv(cls, i), (i < 3) ? "R4" : req, outs(), expv(cls, i));
      chk_inv(i);
      if (i == 2) ir_opcode = op;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(outs() == 12'b0001_0000_0111, "R1", outs(), 12'b0001_0000_0111);
  endtask

  task automatic t_jump();   run_instr(TB_JMP, 2, "R6", 99); endtask
  task automatic t_store();  run_instr(TB_ST, 1, "R7", 99); endtask
  task automatic t_other(input logic [3:0] op); run_instr(op, 0, "R8", 99); endtask

  // R5: default store code is an ordinary opcode under these parameters
  task automatic t_class();
    run_instr(4'h2, 0, "R5", 99);
    run_instr(4'h7, 0, "R5", 99);
  endtask

  // reset while the store is in its write state
  task automatic t_mid_reset();
    run_instr(TB_ST, 1, "R7", 6);
    chk(mem_rnw == 1'b0, "R7", {11'd0, mem_rnw}, 12'd0);
    do_reset();
    run_instr(4'h0, 0, "R8", 99);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_jump();
    t_store();
    t_other(4'h0);
    t_other(4'hF);
    t_class();
    t_store();
    t_jump();
    t_jump();
    t_mid_reset();
    t_store();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule